// File: doc/BRIEF.md
# SPI Command-Byte Decoder

This block is the serial front end of a contactless-reader style peripheral. A host talks to it over a mode-0 SPI link. Each chip-select frame opens with a single command byte, and that byte decides what the rest of the frame does. The frame can write or read a run of registers, fire a data-less action, stream bytes into or out of a data FIFO, load one of three regions of a passive-target configuration memory, or read that memory back. A prefix byte placed ahead of a register command sends the access to an alternate bank or to a test bank.

The block samples SCK, MOSI and CS_n with the fast system clock. It does not execute anything itself. It turns the serial bytes into single-cycle strobes on simple internal ports: a register port, a FIFO port with push/pop, full/empty and show-ahead data, a target-memory port, and an action strobe that carries a 6-bit code. Register and memory read data come back combinationally for the address the block presents. FIFO storage is outside the block.

Top module: `spiCmdDecoder`

## Requirements
- R1: A command byte whose bits 7:6 are 00 starts a register write. Each data byte in the frame produces one regWe pulse, with regWdata equal to that byte. The first pulse uses address bits 5:0 of the command, and each later byte uses the next address.
- R2: A command byte whose bits 7:6 are 01 starts a register read. From the first SCK cycle after the command byte, misoOut returns the register contents MSB first. Consecutive data bytes come from consecutive addresses, with one regRe pulse for each byte fetched.
- R3: During a register burst the 6-bit address wraps from 0x3F to 0x00.
- R4: A command byte whose bits 7:6 are 11, other than the two prefix bytes, gives exactly one cmdStrobe pulse after its eighth bit, with cmdCode equal to bits 5:0. Any further bytes in that frame cause no strobe of any kind.
- R5: The byte 0xFB placed just before a register command sets regBank to 1 for that access. The byte 0xFC sets regBank to 2. With no prefix, regBank is 0. A prefix byte raises no cmdStrobe.
- R6: Command 0x80 pushes each following byte into the FIFO. A byte that arrives while fifoFull is high is dropped and sets fifoOverflow, which then stays high until reset.
- R7: Command 0x9F returns the FIFO head bytes on misoOut. A byte is popped only after all eight of its bits have been clocked out. When the FIFO is empty the block returns 0x00 and does not pop.
- R8: Commands 0xA0, 0xA8 and 0xAC write the following bytes to target-memory region memSel = 0, 1 and 2 respectively, at addresses 0, 1, 2 and so on.
- R9: Command 0xBF returns 0x00 as its first data byte. After that it returns the target memory from address 0 upward.
- R10: Raising CS_n ends the frame. The next frame decodes a new command byte with regBank back at 0. misoOut is low while CS_n is high.
- R11: A command byte with bits 7:6 equal to 10 that is not one of the listed opcodes makes the frame produce no strobe.
- R12: After reset, misoOut and fifoOverflow are low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | SPI clock, mode 0 |
| csNIn | input | 1 | SPI chip select, active low |
| mosiIn | input | 1 | SPI data from host |
| misoOut | output | 1 | SPI data to host, low when deselected |
| regWe | output | 1 | Register write strobe |
| regRe | output | 1 | Register read strobe |
| regBank | output | 2 | Bank select: 0 main, 1 alternate, 2 test |
| regAddr | output | 6 | Register address |
| regWdata | output | 8 | Register write data |
| regRdata | input | 8 | Register read data for regBank/regAddr |
| fifoPush | output | 1 | FIFO push strobe |
| fifoPushData | output | 8 | FIFO push data |
| fifoFull | input | 1 | FIFO full |
| fifoPop | output | 1 | FIFO pop strobe |
| fifoPopData | input | 8 | FIFO head byte (show-ahead) |
| fifoEmpty | input | 1 | FIFO empty |
| fifoOverflow | output | 1 | Sticky push-while-full flag |
| memWe | output | 1 | Target-memory write strobe |
| memSel | output | 2 | Target-memory region: 0, 1 or 2 |
| memAddr | output | MEM_AW | Target-memory address |
| memWdata | output | 8 | Target-memory write data |
| memRdata | input | 8 | Target-memory read data at memAddr |
| cmdStrobe | output | 1 | Direct-action strobe |
| cmdCode | output | 6 | Direct-action code |

## Verification
The bench aims at address wrap in both directions. A decoder that carried into a seventh bit would write or return the wrong register after 0x3F. It checks that FIFO reads pop only fully shifted bytes: a decoder that popped on prefetch would lose one byte at the end of every read frame, and that shows up as a wrong FIFO count. It checks the empty-FIFO zero byte and the dummy byte that leads a memory read, where an off-by-one shifts every returned byte. It also covers prefix bytes: they must change the bank without firing an action, and their effect must not leak into the next frame.

// File: rtl/spiDecPkg.sv
package spiDecPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;

  localparam logic [BYTE_W-1:0] OP_FIFO_LOAD = 8'h80;
  localparam logic [BYTE_W-1:0] OP_FIFO_READ = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_MEM_A     = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_MEM_F     = 8'hA8;
  localparam logic [BYTE_W-1:0] OP_MEM_TSN   = 8'hAC;
  localparam logic [BYTE_W-1:0] OP_MEM_READ  = 8'hBF;

  typedef enum logic [1:0] {BANK_MAIN = 2'd0, BANK_ALT = 2'd1, BANK_TEST = 2'd2} bankE;
  typedef enum logic [1:0] {TX_ZERO, TX_REG, TX_FIFO, TX_MEM} txSrcE;
  typedef enum logic [3:0] {
    M_IDLE, M_REG_WR, M_REG_RD, M_FIFO_WR, M_FIFO_RD,
    M_MEM_WR, M_MEM_DUMMY, M_MEM_RD, M_DONE
  } modeE;

  // strobes from control to datapath
  typedef struct packed {
    logic  clear;
    logic  shiftBit;
    logic  capture;
    logic  loadReg;
    logic  incReg;
    logic  clrMem;
    logic  incMem;
    logic  loadTx;
    txSrcE txSrc;
    logic  shiftTx;
  } dpCtlT;

  function automatic logic isReadMode(modeE m);
    return (m == M_REG_RD) || (m == M_FIFO_RD) || (m == M_MEM_DUMMY) || (m == M_MEM_RD);
  endfunction
endpackage

// File: rtl/spiDecCtrl.sv
module spiDecCtrl
  import spiDecPkg::*;
#(
  parameter logic [ADDR_W-1:0] ALT_CODE  = 6'h3B,
  parameter logic [ADDR_W-1:0] TEST_CODE = 6'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic [BYTE_W-1:0] rxHold,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output dpCtlT             ctl,
  output logic              mosiBit,
  output logic              selected,
  output logic              regWe,
  output logic              regRe,
  output logic [1:0]        regBank,
  output logic              fifoPush,
  output logic              fifoPop,
  output logic              fifoOverflow,
  output logic              memWe,
  output logic [1:0]        memSel,
  output logic              cmdStrobe,
  output logic [ADDR_W-1:0] cmdCode
);
  localparam logic [BYTE_W-1:0] PFX_ALT  = {2'b11, ALT_CODE};
  localparam logic [BYTE_W-1:0] PFX_TEST = {2'b11, TEST_CODE};

  logic [2:0] sckS;
  logic [1:0] mosiS, csS;
  logic [2:0] bitCnt;
  logic       act, fetch, popArm, ovf;
  logic       sckRise, byteDone, ovfSet;
  modeE       mode, decMode;
  bankE       bank, decBank;
  logic [1:0] msel, decSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= '0;
      mosiS <= '0;
      csS   <= '1;
    end else begin
      sckS  <= {sckS[1:0], sckIn};
      mosiS <= {mosiS[0], mosiIn};
      csS   <= {csS[0], csNIn};
    end
  end

  assign sckRise  = sckS[1] & ~sckS[2];
  assign selected = ~csS[1];
  assign mosiBit  = mosiS[1];
  assign byteDone = selected & sckRise & (bitCnt == 3'd7);

  always_comb begin
    ctl          = '0;
    ctl.txSrc    = TX_ZERO;
    ctl.clear    = ~selected;
    ctl.shiftBit = selected & sckRise;
    ctl.shiftTx  = selected & sckRise;
    ctl.capture  = byteDone;
    regWe = 1'b0; regRe = 1'b0; fifoPush = 1'b0; fifoPop = 1'b0;
    memWe = 1'b0; cmdStrobe = 1'b0; ovfSet = 1'b0;
    decMode = mode; decBank = bank; decSel = msel;
    if (act) begin
      unique case (mode)
        M_IDLE: begin
          if (rxHold == OP_FIFO_LOAD)      decMode = M_FIFO_WR;
          else if (rxHold == OP_FIFO_READ) decMode = M_FIFO_RD;
          else if (rxHold == OP_MEM_A)   begin decMode = M_MEM_WR; decSel = 2'd0; ctl.clrMem = 1'b1; end
          else if (rxHold == OP_MEM_F)   begin decMode = M_MEM_WR; decSel = 2'd1; ctl.clrMem = 1'b1; end
          else if (rxHold == OP_MEM_TSN) begin decMode = M_MEM_WR; decSel = 2'd2; ctl.clrMem = 1'b1; end
          else if (rxHold == OP_MEM_READ) begin decMode = M_MEM_DUMMY; ctl.clrMem = 1'b1; end
          else begin
            unique case (rxHold[7:6])
              2'b00: begin decMode = M_REG_WR; ctl.loadReg = 1'b1; end
              2'b01: begin decMode = M_REG_RD; ctl.loadReg = 1'b1; end
              2'b11: begin
                if (rxHold == PFX_ALT)       decBank = BANK_ALT;
                else if (rxHold == PFX_TEST) decBank = BANK_TEST;
                else begin
                  cmdStrobe = 1'b1;
                  decMode   = M_DONE;
                end
              end
              default: decMode = M_DONE;
            endcase
          end
        end
        M_REG_WR:  begin regWe = 1'b1; ctl.incReg = 1'b1; end
        M_FIFO_WR: begin fifoPush = ~fifoFull; ovfSet = fifoFull; end
        M_FIFO_RD: fifoPop = popArm;
        M_MEM_WR:  begin memWe = 1'b1; ctl.incMem = 1'b1; end
        default: ;
      endcase
    end
    if (fetch) begin
      ctl.loadTx = 1'b1;
      unique case (mode)
        M_REG_RD:  begin ctl.txSrc = TX_REG; regRe = 1'b1; ctl.incReg = 1'b1; end
        M_FIFO_RD: ctl.txSrc = fifoEmpty ? TX_ZERO : TX_FIFO;
        M_MEM_RD:  begin ctl.txSrc = TX_MEM; ctl.incMem = 1'b1; end
        default:   ctl.txSrc = TX_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; act <= 1'b0; fetch <= 1'b0; popArm <= 1'b0;
      mode <= M_IDLE; bank <= BANK_MAIN; msel <= 2'd0;
    end else if (!selected) begin
      bitCnt <= '0; act <= 1'b0; fetch <= 1'b0; popArm <= 1'b0;
      mode <= M_IDLE; bank <= BANK_MAIN;
    end else begin
      if (sckRise) bitCnt <= bitCnt + 3'd1;
      act   <= byteDone;
      fetch <= act & isReadMode(decMode);
      mode  <= (fetch && mode == M_MEM_DUMMY) ? M_MEM_RD : decMode;
      bank  <= decBank;
      msel  <= decSel;
      if (fetch && mode == M_FIFO_RD) popArm <= ~fifoEmpty;
      else if (act)                   popArm <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovf <= 1'b0;
    else if (ovfSet) ovf <= 1'b1;
  end

  assign fifoOverflow = ovf;
  assign regBank      = bank;
  assign memSel       = msel;
  assign cmdCode      = rxHold[ADDR_W-1:0];
endmodule

// File: rtl/spiDecDp.sv
module spiDecDp
  import spiDecPkg::*;
#(
  parameter int MEM_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic              mosiBit,
  input  logic [BYTE_W-1:0] regRdata,
  input  logic [BYTE_W-1:0] fifoPopData,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [BYTE_W-1:0] rxHold,
  output logic [ADDR_W-1:0] regAddr,
  output logic [MEM_AW-1:0] memAddr,
  output logic              txBit
);
  logic [BYTE_W-2:0] rxSh;
  logic [BYTE_W-1:0] txSh, txSrcVal;

  always_comb begin
    unique case (ctl.txSrc)
      TX_REG:  txSrcVal = regRdata;
      TX_FIFO: txSrcVal = fifoPopData;
      TX_MEM:  txSrcVal = memRdata;
      default: txSrcVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0; rxHold <= '0; txSh <= '0; regAddr <= '0; memAddr <= '0;
    end else begin
      if (ctl.shiftBit) rxSh <= {rxSh[BYTE_W-3:0], mosiBit};
      if (ctl.capture)  rxHold <= {rxSh, mosiBit};
      if (ctl.clear)        txSh <= '0;
      else if (ctl.loadTx)  txSh <= txSrcVal;
      else if (ctl.shiftTx) txSh <= {txSh[BYTE_W-2:0], 1'b0};
      if (ctl.loadReg)     regAddr <= rxHold[ADDR_W-1:0];
      else if (ctl.incReg) regAddr <= regAddr + 1'b1;
      if (ctl.clrMem)      memAddr <= '0;
      else if (ctl.incMem) memAddr <= memAddr + 1'b1;
    end
  end

  assign txBit = txSh[BYTE_W-1];
endmodule

// File: rtl/spiCmdDecoder.sv
module spiCmdDecoder
  import spiDecPkg::*;
#(
  parameter int                MEM_AW    = 5,
  parameter logic [ADDR_W-1:0] ALT_CODE  = 6'h3B,
  parameter logic [ADDR_W-1:0] TEST_CODE = 6'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              regWe,
  output logic              regRe,
  output logic [1:0]        regBank,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  input  logic [BYTE_W-1:0] regRdata,
  output logic              fifoPush,
  output logic [BYTE_W-1:0] fifoPushData,
  input  logic              fifoFull,
  output logic              fifoPop,
  input  logic [BYTE_W-1:0] fifoPopData,
  input  logic              fifoEmpty,
  output logic              fifoOverflow,
  output logic              memWe,
  output logic [1:0]        memSel,
  output logic [MEM_AW-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              cmdStrobe,
  output logic [ADDR_W-1:0] cmdCode
);
  dpCtlT             ctl;
  logic              mosiBit, selected, txBit;
  logic [BYTE_W-1:0] rxHold;

  spiDecCtrl #(.ALT_CODE(ALT_CODE), .TEST_CODE(TEST_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .rxHold(rxHold), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .ctl(ctl), .mosiBit(mosiBit), .selected(selected),
    .regWe(regWe), .regRe(regRe), .regBank(regBank),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoOverflow(fifoOverflow),
    .memWe(memWe), .memSel(memSel), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
  );

  spiDecDp #(.MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mosiBit(mosiBit),
    .regRdata(regRdata), .fifoPopData(fifoPopData), .memRdata(memRdata),
    .rxHold(rxHold), .regAddr(regAddr), .memAddr(memAddr), .txBit(txBit)
  );

  assign misoOut      = selected & txBit;
  assign regWdata     = rxHold;
  assign fifoPushData = rxHold;
  assign memWdata     = rxHold;
endmodule

// File: rtl/spiCmdDecoderChk.sv
module spiCmdDecoderChk #(
  parameter logic [5:0] ALT_CODE  = 6'h3B,
  parameter logic [5:0] TEST_CODE = 6'h3C
) (
  input logic       clk,
  input logic       rstN,
  input logic       csNIn,
  input logic       misoOut,
  input logic       regWe,
  input logic       regRe,
  input logic [5:0] regAddr,
  input logic       fifoPush,
  input logic       fifoPop,
  input logic       fifoFull,
  input logic       fifoEmpty,
  input logic       fifoOverflow,
  input logic       memWe,
  input logic       cmdStrobe,
  input logic [5:0] cmdCode
);
  logic       haveLast, seenCmd;
  logic [5:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast <= 1'b0; seenCmd <= 1'b0; lastAddr <= '0;
    end else if (csNIn) begin
      haveLast <= 1'b0; seenCmd <= 1'b0;
    end else begin
      if (regWe) begin haveLast <= 1'b1; lastAddr <= regAddr; end
      if (cmdStrobe) seenCmd <= 1'b1;
    end
  end

  // R1: strobes never overlap
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWe, regRe, fifoPush, fifoPop, memWe, cmdStrobe}));
  // R3: write burst steps the address by one with 6-bit wrap
  p_burst_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && haveLast) |-> (regAddr == 6'(lastAddr + 6'd1)));
  // R4: at most one action per frame
  p_cmd_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> !seenCmd);
  // R5: prefix codes never fire an action
  p_prefix_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> (cmdCode != ALT_CODE && cmdCode != TEST_CODE));
  // R6: no push into a full FIFO
  p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoPush);
  // R6: overflow flag is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow);
  // R7: never pop an empty FIFO
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);
  // R10: MISO low once deselect has settled
  p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csNIn && $past(csNIn) && $past(csNIn, 2) && $past(csNIn, 3)) |-> !misoOut);
endmodule

bind spiCmdDecoder spiCmdDecoderChk #(.ALT_CODE(ALT_CODE), .TEST_CODE(TEST_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .csNIn(csNIn), .misoOut(misoOut),
  .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
  .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .fifoOverflow(fifoOverflow), .memWe(memWe), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
);

// File: tb/spiCmdDecoder_tb.sv
module spiCmdDecoder_tb;
  localparam int H  = 8;
  localparam int FD = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic misoOut, regWe, regRe, fifoPush, fifoPop, fifoOverflow, memWe, cmdStrobe;
  logic [1:0] regBank, memSel;
  logic [5:0] regAddr, cmdCode;
  logic [7:0] regWdata, regRdata, fifoPushData, fifoPopData, memWdata, memRdata;
  logic [4:0] memAddr;
  logic fifoFull, fifoEmpty;

  int checks = 0, errors = 0;
  int nWe = 0, nRe = 0, nPush = 0, nPop = 0, nMem = 0, nCmd = 0;
  logic [5:0] lastCode = '0;
  logic [7:0] regsW [4][64];
  logic [7:0] memW [3][32];
  logic [7:0] fq [FD];
  int fHead = 0, fCnt = 0;
  logic [7:0] txBuf [16];
  logic [7:0] rxBuf [16];

  always #2.5 clk = ~clk;

  spiCmdDecoder u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .mosiIn(mosi), .misoOut(misoOut),
    .regWe(regWe), .regRe(regRe), .regBank(regBank), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .fifoPush(fifoPush), .fifoPushData(fifoPushData), .fifoFull(fifoFull),
    .fifoPop(fifoPop), .fifoPopData(fifoPopData), .fifoEmpty(fifoEmpty),
    .fifoOverflow(fifoOverflow), .memWe(memWe), .memSel(memSel), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
  );

  function automatic logic [7:0] rdFn(input int bank, input int addr);
    logic [1:0] b = bank[1:0];
    logic [5:0] a = addr[5:0];
    return {b, a} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] memFn(input int addr);
    logic [7:0] a = addr[7:0];
    return a * 8'd13 + 8'd7;
  endfunction

  assign regRdata    = rdFn(int'(regBank), int'(regAddr));
  assign memRdata    = memFn(int'(memAddr));
  assign fifoEmpty   = (fCnt == 0);
  assign fifoFull    = (fCnt == FD);
  assign fifoPopData = fq[fHead];

  always @(posedge clk) begin
    if (regWe) begin regsW[regBank][regAddr] <= regWdata; nWe <= nWe + 1; end
    if (regRe) nRe <= nRe + 1;
    if (memWe) begin memW[memSel][memAddr] <= memWdata; nMem <= nMem + 1; end
    if (cmdStrobe) begin nCmd <= nCmd + 1; lastCode <= cmdCode; end
    if (fifoPush) begin fq[(fHead + fCnt) % FD] <= fifoPushData; nPush <= nPush + 1; end
    if (fifoPop) begin fHead <= (fHead + 1) % FD; nPop <= nPop + 1; end
    if (fifoPush && !fifoPop) fCnt <= fCnt + 1;
    else if (fifoPop && !fifoPush) fCnt <= fCnt - 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input int n);
    csN = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = txBuf[b][i];
        repeat (H) @(negedge clk);
        rxBuf[b][i] = misoOut;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (H) @(negedge clk);
    csN = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  function automatic int strobeSum();
    return nWe + nRe + nPush + nPop + nMem + nCmd;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int s0, c0, w0;
    void'($urandom(32'd4242));
    for (int b = 0; b < 4; b++) for (int a = 0; a < 64; a++) regsW[b][a] = 8'h00;
    for (int b = 0; b < 3; b++) for (int a = 0; a < 32; a++) memW[b][a] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 miso", misoOut, 0);
    check("R12 overflow", fifoOverflow, 0);
    check("R12 strobes", strobeSum(), 0);

    // R1 write burst, R3 wrap
    txBuf[0] = 8'h3E; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33;
    runFrame(4);
    check("R1 wr 3E", regsW[0][62], 8'h11);
    check("R3 wr 3F", regsW[0][63], 8'h22);
    check("R3 wr wrap 00", regsW[0][0], 8'h33);
    check("R1 we count", nWe, 3);
    check("R10 miso idle", misoOut, 0);

    // R2 read burst with R3 wrap
    txBuf[0] = 8'h7E; for (int k = 1; k < 5; k++) txBuf[k] = 8'h00;
    runFrame(5);
    check("R2 cmd byte miso low", rxBuf[0], 8'h00);
    for (int k = 0; k < 4; k++) check("R2 R3 read data", rxBuf[k + 1], rdFn(0, 62 + k));

    // R5 prefixes
    c0 = nCmd;
    txBuf[0] = 8'hFB; txBuf[1] = 8'h05; txBuf[2] = 8'hC3;
    runFrame(3);
    check("R5 alt bank write", regsW[1][5], 8'hC3);
    check("R5 main untouched", regsW[0][5], 8'h00);
    txBuf[0] = 8'hFC; txBuf[1] = 8'h49; txBuf[2] = 8'h00;
    runFrame(3);
    check("R5 test bank read", rxBuf[2], rdFn(2, 9));
    check("R5 prefix no action", nCmd, c0);

    // R10 prefix does not outlive frame
    txBuf[0] = 8'hFB; runFrame(1);
    txBuf[0] = 8'h07; txBuf[1] = 8'h9A; runFrame(2);
    check("R10 bank reset", regsW[0][7], 8'h9A);
    check("R10 alt untouched", regsW[1][7], 8'h00);

    // R4 direct action, trailing bytes ignored
    s0 = strobeSum();
    txBuf[0] = 8'hC0 | 8'h15; txBuf[1] = 8'h00; txBuf[2] = 8'h44;
    runFrame(3);
    check("R4 one action", strobeSum() - s0, 1);
    check("R4 code", lastCode, 6'h15);

    // R11 undefined opcode
    s0 = strobeSum();
    txBuf[0] = 8'h85; txBuf[1] = 8'h12; txBuf[2] = 8'h34;
    runFrame(3);
    check("R11 no strobes", strobeSum() - s0, 0);

    // R6 FIFO load with overflow
    txBuf[0] = 8'h80;
    for (int k = 1; k <= 10; k++) txBuf[k] = 8'(8'h40 + k);
    runFrame(11);
    check("R6 push count", nPush, FD);
    check("R6 fifo level", fCnt, FD);
    check("R6 overflow set", fifoOverflow, 1);

    // R7 FIFO read: pop only shifted bytes
    txBuf[0] = 8'h9F; for (int k = 1; k <= 3; k++) txBuf[k] = 8'h00;
    runFrame(4);
    for (int k = 0; k < 3; k++) check("R7 fifo data", rxBuf[k + 1], 8'(8'h41 + k));
    check("R7 pop count", fCnt, FD - 3);
    txBuf[0] = 8'h9F; for (int k = 1; k <= 6; k++) txBuf[k] = 8'h00;
    runFrame(7);
    for (int k = 0; k < 5; k++) check("R7 fifo data 2", rxBuf[k + 1], 8'(8'h44 + k));
    check("R7 empty gives zero", rxBuf[6], 8'h00);
    check("R7 no pop on empty", nPop, FD);
    check("R6 overflow sticky", fifoOverflow, 1);

    // R8 target memory loads
    txBuf[0] = 8'hA8; txBuf[1] = 8'h5C; txBuf[2] = 8'h6D; txBuf[3] = 8'h7E;
    runFrame(4);
    check("R8 F region 0", memW[1][0], 8'h5C);
    check("R8 F region 2", memW[1][2], 8'h7E);
    txBuf[0] = 8'hAC; txBuf[1] = 8'h91; runFrame(2);
    check("R8 TSN region", memW[2][0], 8'h91);
    txBuf[0] = 8'hA0; txBuf[1] = 8'h27; txBuf[2] = 8'h28; runFrame(3);
    check("R8 A region 1", memW[0][1], 8'h28);

    // R9 memory read with dummy byte
    txBuf[0] = 8'hBF; for (int k = 1; k <= 4; k++) txBuf[k] = 8'h00;
    runFrame(5);
    check("R9 dummy", rxBuf[1], 8'h00);
    for (int k = 0; k < 3; k++) check("R9 mem data", rxBuf[k + 2], memFn(k));

    // random register bursts
    for (int t = 0; t < 30; t++) begin
      int bk, addr, len, rd, idx, base;
      bk = $urandom_range(0, 2); addr = $urandom_range(0, 63);
      len = $urandom_range(1, 5); rd = $urandom_range(0, 1);
      idx = 0;
      if (bk == 1) begin txBuf[idx] = 8'hFB; idx++; end
      else if (bk == 2) begin txBuf[idx] = 8'hFC; idx++; end
      txBuf[idx] = {(rd != 0) ? 2'b01 : 2'b00, 6'(addr)}; idx++;
      base = idx;
      for (int k = 0; k < len; k++) begin
        txBuf[idx] = (rd != 0) ? 8'h00 : 8'($urandom);
        idx++;
      end
      w0 = nWe;
      runFrame(idx);
      for (int k = 0; k < len; k++) begin
        if (rd != 0) check("R2 random read", rxBuf[base + k], rdFn(bk, addr + k));
        else check("R1 random write", regsW[bk][(addr + k) % 64], txBuf[base + k]);
      end
      if (rd == 0) check("R1 random we count", nWe - w0, len);
    end

    finishRun();
  end
endmodule